// File: doc/BRIEF.md
# Prioritized Interrupt Vector Sequencer

This block sits beside a small 16-bit processor core and handles the hardware side of interrupt entry and return. Up to sixteen request lines are watched. When the core signals an instruction boundary and the global enable bit of the live status word is set, the highest pending request is chosen. The block then saves the program counter and the status word on a descending stack in memory. Next it fetches the handler address from a table of sixteen words that ends the address space, and hands the core a new program counter, status word and stack pointer in a single update cycle.

A return request runs the opposite sequence. The status word is read from the top of stack, then the program counter, and both are handed back with the stack pointer moved past them. Both sequences use one word-wide memory port whose read data is valid in the same cycle as the request. Once a sequence has started it runs to the end. Request lines, boundary strobes and return requests that arrive during it have no effect.

Top module: `irq_vector_seq`

## Requirements
- R1: After reset the block is idle: busy_o, mem_req_o, ctx_we_o and ack_o are all 0.
- R2: Request line i owns the vector word at address 0xFFE0 + 2*i. Among the pending lines the highest index wins. On entry the new pc_o is the word read from that address, and ack_o pulses with ack_id_o = i.
- R3: Entry writes pc_i to sp_i-2 first and sr_i to sp_i-4 second. The final stack pointer sp_o is sp_i-4, so the status word sits on top of the stack.
- R4: Return reads the status word at sp_i first and the program counter at sp_i+2 second. It presents those two words on sr_o and pc_o with sp_o = sp_i+4, and ack_o stays 0.
- R5: No entry starts while bit 3 of sr_i (the global enable) is 0, whatever the request lines hold.
- R6: The status word presented at the end of entry equals sr_i as stacked, with bit 3 cleared and every other bit unchanged.
- R7: Requests are taken only in a cycle where boundary_i is 1. With boundary_i at 0 the block stays idle.
- R8: During a sequence, changes on irq_i, boundary_i and reti_i neither alter the chosen source nor lengthen the sequence, and they start nothing after it.
- R9: ctx_we_o is 1 for exactly one cycle per sequence. That cycle is the third clock after the accepting edge on entry and the second on return, and busy_o is 1 from the accepting edge until the clock that follows it.
- R10: If reti_i and a takeable request meet in the same idle cycle, the return sequence runs. Its first memory access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Request lines, index = priority |
| boundary_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Start a return sequence |
| pc_i | input | 16 | Live program counter |
| sr_i | input | 16 | Live status word, bit 3 = global enable |
| sp_i | input | 16 | Live stack pointer |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, same cycle |
| ctx_we_o | output | 1 | Load pc_o, sr_o, sp_o into the core |
| pc_o | output | 16 | New program counter |
| sr_o | output | 16 | New status word |
| sp_o | output | 16 | New stack pointer |
| ack_o | output | 1 | Entry completed for ack_id_o |
| ack_id_o | output | 4 | Index of the serviced line |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions assume that the memory returns the addressed word in the cycle it is requested, and that sp_i is even. They also assume the core does not start a return while a sequence is running. The bench sends every request pattern with a sequence-aligned stack pointer and models the memory as a combinational array. It pulses reti_i during busy cycles only to check that the pulse has no effect. After each entry it feeds the stack pointer the entry produced into the return sequence, as a core would, so every stacked word is read back from the address it was written to.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PUSH_PC,
    SEQ_PUSH_SR,
    SEQ_VEC,
    SEQ_POP_SR,
    SEQ_POP_PC
  } seq_state_e;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_IRQ = 16,
  parameter int IDW     = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               en_i,
  output logic               valid_o,
  output logic [IDW-1:0]     idx_o
);
  logic any;

  // last hit in an ascending scan is the highest index
  always_comb begin
    any   = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (irq_i[i]) begin
        any   = 1'b1;
        idx_o = IDW'(i);
      end
    end
  end

  assign valid_o = any & en_i;

  always_comb begin
    if (valid_o) begin
      assert_top_pick_R2: assert (irq_i[idx_o] && ((irq_i >> idx_o) >> 1) == '0);
    end
    assert_gie_gate_R5: assert (en_i || !valid_o);
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int IDW     = 4,
  parameter int NUM_IRQ = 16,
  parameter int GIE_BIT = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           boundary_i,
  input  logic           take_i,
  input  logic [IDW-1:0] id_i,
  input  logic           reti_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [DW-1:0]  sr_i,
  input  logic [AW-1:0]  sp_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           ctx_we_o,
  output logic [AW-1:0]  pc_o,
  output logic [DW-1:0]  sr_o,
  output logic [AW-1:0]  sp_o,
  output logic           ack_o,
  output logic [IDW-1:0] ack_id_o,
  output logic           busy_o
);
  localparam int unsigned VEC_BASE_I = (1 << AW) - 2 * NUM_IRQ;
  localparam logic [AW-1:0] VEC_BASE = AW'(VEC_BASE_I);
  localparam logic [AW-1:0] WSTEP    = AW'(2);
  localparam logic [DW-1:0] GIE_MASK = DW'(1) << GIE_BIT;

  seq_state_e     state_q;
  logic [IDW-1:0] id_q;
  logic [AW-1:0]  sp_q, pc_q;
  logic [DW-1:0]  sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      id_q    <= '0;
      sp_q    <= '0;
      pc_q    <= '0;
      sr_q    <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (reti_i) begin
            sp_q    <= sp_i;
            state_q <= SEQ_POP_SR;
          end else if (boundary_i && take_i) begin
            id_q    <= id_i;
            pc_q    <= pc_i;
            sr_q    <= sr_i;
            sp_q    <= sp_i - WSTEP;
            state_q <= SEQ_PUSH_PC;
          end
        end
        SEQ_PUSH_PC: begin
          sp_q    <= sp_q - WSTEP;
          state_q <= SEQ_PUSH_SR;
        end
        SEQ_PUSH_SR: state_q <= SEQ_VEC;
        SEQ_VEC:     state_q <= SEQ_IDLE;
        SEQ_POP_SR: begin
          sr_q    <= mem_rdata_i;
          sp_q    <= sp_q + WSTEP;
          state_q <= SEQ_POP_PC;
        end
        SEQ_POP_PC:  state_q <= SEQ_IDLE;
        default:     state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = state_q != SEQ_IDLE;
    mem_we_o    = (state_q == SEQ_PUSH_PC) || (state_q == SEQ_PUSH_SR);
    mem_addr_o  = (state_q == SEQ_VEC) ? VEC_BASE + AW'({id_q, 1'b0}) : sp_q;
    mem_wdata_o = (state_q == SEQ_PUSH_PC) ? DW'(pc_q) :
                  (state_q == SEQ_PUSH_SR) ? sr_q : '0;
  end

  assign ctx_we_o = (state_q == SEQ_VEC) || (state_q == SEQ_POP_PC);
  assign pc_o     = AW'(mem_rdata_i);
  assign sr_o     = (state_q == SEQ_VEC) ? (sr_q & ~GIE_MASK) : sr_q;
  assign sp_o     = (state_q == SEQ_POP_PC) ? sp_q + WSTEP : sp_q;
  assign ack_o    = state_q == SEQ_VEC;
  assign ack_id_o = id_q;
  assign busy_o   = state_q != SEQ_IDLE;

  assert_push_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_PUSH_PC) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) - WSTEP));

  assert_pop_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_POP_SR) |=> (!mem_we_o && mem_addr_o == $past(mem_addr_o) + WSTEP));

  assert_gie_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !sr_o[GIE_BIT]);

  assert_no_preempt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ctx_we_o) |=> (busy_o && $stable(id_q)));

  assert_entry_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_PUSH_PC) |=> ##1 (ctx_we_o && ack_o));

  assert_ret_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && reti_i) |=> (mem_req_o && !mem_we_o && !ack_o));
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq #(
  parameter int NUM_IRQ = 16,
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int GIE_BIT = 3,
  localparam int IDW    = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               boundary_i,
  input  logic               reti_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [DW-1:0]      sr_i,
  input  logic [AW-1:0]      sp_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               ctx_we_o,
  output logic [AW-1:0]      pc_o,
  output logic [DW-1:0]      sr_o,
  output logic [AW-1:0]      sp_o,
  output logic               ack_o,
  output logic [IDW-1:0]     ack_id_o,
  output logic               busy_o
);
  logic           take;
  logic [IDW-1:0] pick;

  irq_prio_arb #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_arb (
    .irq_i   (irq_i),
    .en_i    (sr_i[GIE_BIT]),
    .valid_o (take),
    .idx_o   (pick)
  );

  irq_stack_seq #(
    .AW(AW), .DW(DW), .IDW(IDW), .NUM_IRQ(NUM_IRQ), .GIE_BIT(GIE_BIT)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary_i),
    .take_i      (take),
    .id_i        (pick),
    .reti_i      (reti_i),
    .pc_i        (pc_i),
    .sr_i        (sr_i),
    .sp_i        (sp_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .ctx_we_o    (ctx_we_o),
    .pc_o        (pc_o),
    .sr_o        (sr_o),
    .sp_o        (sp_o),
    .ack_o       (ack_o),
    .ack_id_o    (ack_id_o),
    .busy_o      (busy_o)
  );
endmodule

// File: tb/irq_vector_seq_bench.sv
`timescale 1ns/1ps
module irq_vector_seq_bench;
  logic        clk = 0, rst_n = 0;
  logic [15:0] irq = '0;
  logic        boundary = 0, reti = 0;
  logic [15:0] pc_in = '0, sr_in = '0, sp_in = '0;
  logic        mem_req, mem_we, ctx_we, ack, busy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_out, sr_out, sp_out;
  logic [3:0]  ack_id;
  logic [15:0] mem [32768];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[15:1]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[15:1]] <= mem_wdata;

  irq_vector_seq u_irq_vector_seq (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .boundary_i(boundary), .reti_i(reti),
    .pc_i(pc_in), .sr_i(sr_in), .sp_i(sp_in),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .ctx_we_o(ctx_we), .pc_o(pc_out), .sr_o(sr_out), .sp_o(sp_out),
    .ack_o(ack), .ack_id_o(ack_id), .busy_o(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_word(input int i);
    return 16'h4000 | 16'(i << 4) | 16'h0002;
  endfunction

  task automatic run_entry(input int idx, input logic [15:0] lines, input logic [15:0] pc,
                           input logic [15:0] sr, input logic [15:0] sp);
    int n;
    @(negedge clk);
    irq = lines; pc_in = pc; sr_in = sr; sp_in = sp; boundary = 1;
    @(posedge clk);
    @(negedge clk);
    n = 1;
    chk("R9 busy after accept", busy, 1);
    irq = 16'hFFFF; boundary = 1; reti = 1;   // R8 noise while busy
    while (!ctx_we && n < 8) begin
      @(negedge clk); n++;
      boundary = 0; reti = 0; irq = 16'h0;
    end
    chk("R9 entry length", n, 3);
    chk("R2 vector address", mem_addr, 16'hFFE0 + 16'(2 * idx));
    chk("R2 new pc", pc_out, vec_word(idx));
    chk("R2 ack", ack, 1);
    chk("R8 ack id", ack_id, idx);
    chk("R6 sr gie cleared", sr_out, sr & ~16'h0008);
    chk("R3 final sp", sp_out, sp - 16'd4);
    chk("R3 pc stacked first", mem[(sp - 16'd2) >> 1], pc);
    chk("R3 sr on top", mem[(sp - 16'd4) >> 1], sr);
    @(negedge clk);
    chk("R9 single update", ctx_we, 0);
    chk("R8 nothing after", busy, 0);
  endtask

  task automatic run_return(input logic [15:0] sp, input logic [15:0] pc, input logic [15:0] sr,
                            input bit with_irq);
    int n;
    @(negedge clk);
    sp_in = sp; reti = 1;
    if (with_irq) begin irq = 16'h8001; boundary = 1; sr_in = 16'h0008; end
    @(posedge clk);
    @(negedge clk);
    n = 1;
    chk("R10 return reads first", {mem_req, mem_we}, 2'b10);
    reti = 0; boundary = 0; irq = '0;
    while (!ctx_we && n < 8) begin @(negedge clk); n++; end
    chk("R9 return length", n, 2);
    chk("R4 restored pc", pc_out, pc);
    chk("R4 restored sr", sr_out, sr);
    chk("R4 final sp", sp_out, sp + 16'd4);
    chk("R4 no ack", ack, 0);
    @(negedge clk);
    chk("R9 return done", busy, 0);
  endtask

  initial begin
    for (int a = 0; a < 32768; a++) mem[a] = '0;
    for (int i = 0; i < 16; i++) mem[(16'hFFE0 >> 1) + i] = vec_word(i);
    repeat (2) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 ctx_we", ctx_we, 0);
    chk("R1 ack", ack, 0);
    rst_n = 1;

    for (int i = 0; i < 16; i++) begin
      logic [15:0] low, lines, pc, sr, sp;
      low   = (16'hA5C3 ^ 16'(i * 16'h1111)) & ((16'd1 << i) - 16'd1);
      lines = (16'd1 << i) | low;
      pc    = 16'h8000 + 16'(i * 6);
      sr    = 16'(i * 37) | 16'h0008;
      sp    = 16'h0A00 - 16'(i * 8);
      run_entry(i, lines, pc, sr, sp);
      run_return(sp - 16'd4, pc, sr, i[0]);
    end

    // R5: enable bit clear, every line pending
    @(negedge clk);
    irq = 16'hFFFF; sr_in = 16'hFFF7; boundary = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 masked stays idle", {busy, mem_req}, 2'b00);
    end
    // R7: enabled and pending but no boundary strobe
    boundary = 0; sr_in = 16'h0008;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 no boundary stays idle", {busy, mem_req}, 2'b00);
    end
    irq = '0;
    run_entry(5, 16'h0020, 16'h1234, 16'h0108, 16'h0300);
    run_return(16'h02FC, 16'h1234, 16'h0108, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule